// File: doc/BRIEF.md
# Queued Serial Transceiver with Receiver Wake-Up

This block is an asynchronous serial transceiver with a small queue in each direction. Words written into the transmit queue are sent as frames with a low start bit, eight or nine data bits LSB first, and one high stop bit. Frames recovered from the line are placed in the receive queue, and the head of that queue is always visible on `rx_data`. One clock-rate divider sets a sampling tick at sixteen times the bit rate, and both directions use it.

The line can work in two ways. In full-duplex mode the transmitter drives `ser_out` at all times and the receiver listens on `ser_in`. In single-wire mode both directions share one external line. The output enable `tx_oe` is raised only while a frame is going out. The receiver either hears its own frames or, when asked, ignores them.

The receiver can be put to sleep so that a node on a shared bus skips traffic meant for others. It wakes in one of two ways. In idle mode it wakes after the line has stayed high for one whole frame time. In address mode it wakes on a frame whose top data bit is set.

Top module: `wake_uart`

## Requirements
- R1: After a synchronous reset `ser_out` is 1, `tx_empty` is 1, `rx_avail` is 0, `asleep`, `frame_err` and `overrun` are 0, and `tx_oe` is 1 when `single_wire` is 0.
- R2: A frame is one start bit of 0, then the data bits LSB first, then one stop bit of 1. There are 9 data bits when `nine_bit` or `wake_addr` is 1, and 8 otherwise. Each bit lasts 16 ticks, and a tick comes every `baud_div`+1 clocks. A word sent in loopback comes back unchanged.
- R3: The transmit queue holds 4 words, and one more word can be in flight. `tx_empty` is 1 only when the queue holds nothing. `tx_full` is 1 when the queue holds 4 words, and a push while it is full is ignored.
- R4: The receive queue holds 4 words in arrival order. `rx_avail` is 1 while it holds a word, and `rx_data` shows the oldest word. `rx_pop` removes that word.
- R5: If a frame is accepted while the receive queue is full, `overrun` goes to 1 and stays there, the new word is dropped, and the words already in the queue are kept.
- R6: Each bit is decided by a majority vote of samples 7, 8 and 9 of its 16 ticks. A disturbance that lasts one tick does not change the received word.
- R7: A stop bit that is sampled low sets `frame_err`, which stays set until `err_clr`. The word is still stored.
- R8: A pulse on `sleep_req` puts the receiver to sleep. With `wake_addr`=0, frames received while asleep are discarded. The receiver wakes after 16×(data bits+2) consecutive ticks of high line.
- R9: With `wake_addr`=1, a frame received while asleep whose bit 8 is 0 is discarded and the receiver stays asleep. A frame with bit 8 = 1 wakes the receiver and is stored.
- R10: With `single_wire`=1, `tx_oe` is 1 only while a frame is being sent, and `ser_out` is 1 whenever `tx_oe` is 0. The receiver hears the frame it sends.
- R11: With `single_wire`=1 and `echo_ignore`=1, the receiver does not store its own frames, but it still receives frames driven by another node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | DIV_W | Tick period minus one, in clocks |
| nine_bit | input | 1 | Select 9 data bits |
| wake_addr | input | 1 | Wake-up method: 0 idle line, 1 address frame (forces 9 bits) |
| single_wire | input | 1 | Shared-line mode |
| echo_ignore | input | 1 | In shared-line mode, ignore own frames |
| sleep_req | input | 1 | Pulse to put the receiver to sleep |
| err_clr | input | 1 | Clear `frame_err` and `overrun` |
| tx_data | input | 9 | Word to queue for sending |
| tx_push | input | 1 | Write `tx_data` into the transmit queue |
| tx_empty | output | 1 | Transmit queue is empty |
| tx_full | output | 1 | Transmit queue is full |
| rx_pop | input | 1 | Remove the oldest received word |
| rx_data | output | 9 | Oldest received word |
| rx_avail | output | 1 | Receive queue is not empty |
| asleep | output | 1 | Receiver is asleep |
| frame_err | output | 1 | Sticky framing error |
| overrun | output | 1 | Sticky overrun |
| ser_in | input | 1 | Serial line input |
| ser_out | output | 1 | Serial line output |
| tx_oe | output | 1 | Output enable for `ser_out` |

## Verification
The bench builds the block with queue depth 4 and a 16-bit divider, and runs it with `baud_div` = 1. A tick then comes every two clocks and an 8-bit frame takes 320 clocks. That keeps a loopback of all 256 byte values within the run, together with the 9-bit extremes. The depth of 4 means five frames are enough to reach the overrun case and six pushes the full transmit queue. A glitch of two clocks covers exactly one tick sample, so the vote can be tested on every data bit. Both wake-up methods and both single-wire echo settings are driven from a modelled remote node.

// File: rtl/wuart_pkg.sv
package wuart_pkg;
  localparam int unsigned OVS = 16;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/wuart_fifo.sv
module wuart_fifo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign do_wr = push & ~full;
  assign do_rd = pop & ~empty;
  assign rdata = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R3/R5: a write into a full queue leaves the fill level unchanged
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/wuart_tx.sv
module wuart_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       nine,
  input  logic       has_data,
  input  logic [8:0] data,
  output logic       pop,
  output logic       ser_out,
  output logic       busy
);
  import wuart_pkg::*;

  logic [10:0] sh;
  logic [3:0]  sub;
  logic [3:0]  bit_idx;
  logic [3:0]  last_bit;

  assign last_bit = nine ? 4'd10 : 4'd9;
  assign pop      = tick & ~busy & has_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sh      <= '1;
      sub     <= '0;
      bit_idx <= '0;
      ser_out <= 1'b1;
    end else if (tick) begin
      if (!busy) begin
        if (has_data) begin
          busy    <= 1'b1;
          sub     <= '0;
          bit_idx <= '0;
          ser_out <= 1'b0;
          sh      <= nine ? {1'b1, data, 1'b0} : {2'b11, data[7:0], 1'b0};
        end
      end else begin
        sub <= sub + 4'd1;
        if (sub == 4'(OVS - 1)) begin
          if (bit_idx == last_bit) begin
            busy    <= 1'b0;
            ser_out <= 1'b1;
          end else begin
            sh      <= {1'b1, sh[10:1]};
            bit_idx <= bit_idx + 4'd1;
            ser_out <= sh[1];
          end
        end
      end
    end
  end

  // R2: the bit index never runs past the stop bit of the frame
  p_bit_index_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bit_idx <= last_bit));
endmodule

// File: rtl/wuart_rx.sv
module wuart_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       nine,
  input  logic       line,
  output logic       done,
  output logic       stop_ok,
  output logic [8:0] data
);
  import wuart_pkg::*;

  rx_state_t  state;
  logic [3:0] sub;
  logic [3:0] cnt;
  logic [3:0] nbits;
  logic       s7, s8, v;
  logic [8:0] sh;

  assign nbits = nine ? 4'd9 : 4'd8;
  assign v     = vote3(s7, s8, line);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      sub     <= '0;
      cnt     <= '0;
      s7      <= 1'b1;
      s8      <= 1'b1;
      sh      <= '0;
      done    <= 1'b0;
      stop_ok <= 1'b1;
      data    <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (state == RX_IDLE) begin
          if (!line) begin
            state <= RX_START;
            sub   <= 4'd1;
          end
        end else begin
          sub <= sub + 4'd1;
          if (sub == 4'd7) s7 <= line;
          if (sub == 4'd8) s8 <= line;
          if (sub == 4'd9) begin
            case (state)
              RX_START: if (v) state <= RX_IDLE;
              RX_DATA: begin
                sh  <= nine ? {v, sh[8:1]} : {1'b0, v, sh[7:1]};
                cnt <= cnt + 4'd1;
              end
              RX_STOP: begin
                done    <= 1'b1;
                stop_ok <= v;
                data    <= sh;
                state   <= RX_IDLE;
              end
              default: ;
            endcase
          end
          if (sub == 4'(OVS - 1)) begin
            if (state == RX_START) begin
              state <= RX_DATA;
              cnt   <= '0;
            end else if (state == RX_DATA && cnt == nbits) begin
              state <= RX_STOP;
            end
          end
        end
      end
    end
  end

  // R6: a frame completion is a single-cycle event
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/wuart_wake.sv
module wuart_wake (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic nine,
  input  logic mode_addr,
  input  logic sleep_req,
  input  logic line,
  input  logic frame_done,
  input  logic frame_msb,
  output logic asleep,
  output logic accept
);
  import wuart_pkg::*;

  localparam int unsigned IW = $clog2(OVS * 11 + 1);

  logic [IW-1:0] idle_cnt;
  logic [IW-1:0] idle_thr;

  assign idle_thr = nine ? IW'(OVS * 11) : IW'(OVS * 10);
  assign accept   = frame_done & (~asleep | (mode_addr & frame_msb));

  always_ff @(posedge clk) begin
    if (rst) begin
      asleep   <= 1'b0;
      idle_cnt <= '0;
    end else if (sleep_req) begin
      asleep   <= 1'b1;
      idle_cnt <= '0;
    end else if (asleep) begin
      if (mode_addr) begin
        idle_cnt <= '0;
        if (frame_done && frame_msb) asleep <= 1'b0;
      end else if (!line) begin
        idle_cnt <= '0;
      end else if (tick) begin
        if (idle_cnt == idle_thr - IW'(1)) begin
          asleep   <= 1'b0;
          idle_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + IW'(1);
        end
      end
    end else begin
      idle_cnt <= '0;
    end
  end

  // R9: a data frame (bit 8 clear) never wakes a receiver in address mode
  p_addr_wake_r9: assert property (@(posedge clk) disable iff (rst)
    (asleep && mode_addr && frame_done && !frame_msb && !sleep_req) |=> asleep);
endmodule

// File: rtl/wake_uart.sv
module wake_uart #(
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             nine_bit,
  input  logic             wake_addr,
  input  logic             single_wire,
  input  logic             echo_ignore,
  input  logic             sleep_req,
  input  logic             err_clr,
  input  logic [8:0]       tx_data,
  input  logic             tx_push,
  output logic             tx_empty,
  output logic             tx_full,
  input  logic             rx_pop,
  output logic [8:0]       rx_data,
  output logic             rx_avail,
  output logic             asleep,
  output logic             frame_err,
  output logic             overrun,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             tx_oe
);
  localparam int unsigned FW = 9;

  logic [DIV_W-1:0]       div_cnt;
  logic                   tick;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   nine_eff;
  logic                   rx_line;

  logic [FW-1:0] txq_data;
  logic          txq_empty, txq_pop, tx_busy;
  logic [FW-1:0] rx_word;
  logic          rx_done, rx_stop_ok, rx_accept, rxq_empty, rxq_full;

  assign nine_eff = nine_bit | wake_addr;
  assign tick     = (div_cnt == baud_div);

  always_ff @(posedge clk) begin
    if (rst || tick) div_cnt <= '0;
    else             div_cnt <= div_cnt + DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], ser_in};
  end

  assign rx_line = (single_wire && echo_ignore && tx_busy) ? 1'b1 : sync_q[SYNC_STAGES-1];

  wuart_fifo #(.W(FW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .wdata(tx_data), .pop(txq_pop),
    .rdata(txq_data), .empty(txq_empty), .full(tx_full)
  );

  wuart_tx u_tx (
    .clk(clk), .rst(rst), .tick(tick), .nine(nine_eff), .has_data(~txq_empty),
    .data(txq_data), .pop(txq_pop), .ser_out(ser_out), .busy(tx_busy)
  );

  wuart_rx u_rx (
    .clk(clk), .rst(rst), .tick(tick), .nine(nine_eff), .line(rx_line),
    .done(rx_done), .stop_ok(rx_stop_ok), .data(rx_word)
  );

  wuart_wake u_wake (
    .clk(clk), .rst(rst), .tick(tick), .nine(nine_eff), .mode_addr(wake_addr),
    .sleep_req(sleep_req), .line(rx_line), .frame_done(rx_done),
    .frame_msb(rx_word[FW-1]), .asleep(asleep), .accept(rx_accept)
  );

  wuart_fifo #(.W(FW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_accept), .wdata(rx_word), .pop(rx_pop),
    .rdata(rx_data), .empty(rxq_empty), .full(rxq_full)
  );

  always_ff @(posedge clk) begin
    if (rst || err_clr) begin
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (rx_accept && !rx_stop_ok) frame_err <= 1'b1;
      if (rx_accept && rxq_full)    overrun   <= 1'b1;
    end
  end

  assign tx_empty = txq_empty;
  assign rx_avail = ~rxq_empty;
  assign tx_oe    = ~single_wire | tx_busy;

  // R10: with the driver released the transmitter rests at the idle level
  p_released_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (single_wire && !tx_oe) |-> ser_out);
endmodule

// File: tb/tb_wake_uart.sv
`timescale 1ns/1ps
module tb_wake_uart;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [15:0] baud_div = 16'd1;
  logic nine_bit = 0, wake_addr = 0, single_wire = 0, echo_ignore = 0;
  logic sleep_req = 0, err_clr = 0, tx_push = 0, rx_pop = 0;
  logic [8:0] tx_data = '0;
  logic tx_empty, tx_full, rx_avail, asleep, frame_err, overrun, ser_out, tx_oe;
  logic [8:0] rx_data;
  logic loop = 0, remote = 1;
  logic ser_in;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  localparam int BIT_CLK = 32;

  always #10 clk = ~clk;

  assign ser_in = loop ? ser_out : ((single_wire && tx_oe) ? ser_out : remote);

  wake_uart dut (
    .clk(clk), .rst(rst), .baud_div(baud_div), .nine_bit(nine_bit), .wake_addr(wake_addr),
    .single_wire(single_wire), .echo_ignore(echo_ignore), .sleep_req(sleep_req),
    .err_clr(err_clr), .tx_data(tx_data), .tx_push(tx_push), .tx_empty(tx_empty),
    .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data), .rx_avail(rx_avail),
    .asleep(asleep), .frame_err(frame_err), .overrun(overrun), .ser_in(ser_in),
    .ser_out(ser_out), .tx_oe(tx_oe)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [8:0] v);
    @(negedge clk); tx_data = v; tx_push = 1;
    @(negedge clk); tx_push = 0;
  endtask

  task automatic pop_check(input string tag, input logic [8:0] exp);
    @(negedge clk);
    check({tag, " avail"}, 16'(rx_avail), 16'd1);
    check(tag, 16'(rx_data), 16'(exp));
    rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  task automatic drive_bit(input logic b, input logic glitch);
    remote = b;
    if (glitch) begin
      wait_clk(16); remote = ~b; wait_clk(2); remote = b; wait_clk(14);
    end else begin
      wait_clk(BIT_CLK);
    end
  endtask

  task automatic send_frame(input logic [8:0] v, input int nb, input logic stop_v, input logic glitch);
    @(negedge clk);
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) drive_bit(v[i], glitch);
    drive_bit(stop_v, 1'b0);
    remote = 1'b1;
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    wait_clk(4);
    rst = 0;
    wait_clk(2);
    // R1: reset state
    check("R1 ser_out", 16'(ser_out), 16'd1);
    check("R1 tx_empty", 16'(tx_empty), 16'd1);
    check("R1 rx_avail", 16'(rx_avail), 16'd0);
    check("R1 flags", {13'd0, asleep, frame_err, overrun}, 16'd0);
    check("R1 tx_oe", 16'(tx_oe), 16'd1);

    // R2/R4: every byte value through loopback, four at a time
    loop = 1;
    for (int base = 0; base < 256; base += 4) begin
      for (int k = 0; k < 4; k++) push(9'(base + k));
      wait_clk(4 * 320 + 40);
      for (int k = 0; k < 4; k++) pop_check("R2 loop8", 9'(base + k));
    end
    check("R4 drained", 16'(rx_avail), 16'd0);

    // R2: nine data bits
    nine_bit = 1;
    push(9'h1FF); push(9'h100); push(9'h0AA); push(9'h155);
    wait_clk(4 * 352 + 40);
    pop_check("R2 loop9", 9'h1FF);
    pop_check("R2 loop9", 9'h100);
    pop_check("R2 loop9", 9'h0AA);
    pop_check("R2 loop9", 9'h155);
    nine_bit = 0;

    // R3: six pushes, queue of four plus one in flight, sixth dropped
    for (int k = 0; k < 6; k++) push(9'h0A0 + 9'(k));
    check("R3 tx_full", 16'(tx_full), 16'd1);
    check("R3 tx_empty low", 16'(tx_empty), 16'd0);
    for (int k = 0; k < 5; k++) begin
      wait_clk(340);
      pop_check("R3 order", 9'h0A0 + 9'(k));
    end
    wait_clk(400);
    check("R3 sixth dropped", 16'(rx_avail), 16'd0);
    check("R3 tx_empty", 16'(tx_empty), 16'd1);
    loop = 0;

    // R6: one-tick glitch at the middle of every data bit
    send_frame(9'h096, 8, 1'b1, 1'b1);
    wait_clk(4);
    pop_check("R6 glitch", 9'h096);
    send_frame(9'h069, 8, 1'b1, 1'b1);
    wait_clk(4);
    pop_check("R6 glitch", 9'h069);

    // R7: low stop bit
    send_frame(9'h0A7, 8, 1'b0, 1'b0);
    wait_clk(BIT_CLK * 2);
    check("R7 frame_err", 16'(frame_err), 16'd1);
    pop_check("R7 data kept", 9'h0A7);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    check("R7 cleared", 16'(frame_err), 16'd0);

    // R5: five frames into a queue of four
    for (int k = 0; k < 5; k++) send_frame(9'h011 + 9'(k), 8, 1'b1, 1'b0);
    wait_clk(4);
    check("R5 overrun", 16'(overrun), 16'd1);
    for (int k = 0; k < 4; k++) pop_check("R5 kept", 9'h011 + 9'(k));
    check("R5 dropped", 16'(rx_avail), 16'd0);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    check("R5 cleared", 16'(overrun), 16'd0);

    // R8: idle-line wake
    @(negedge clk); sleep_req = 1; @(negedge clk); sleep_req = 0;
    wait_clk(10);
    send_frame(9'h03C, 8, 1'b1, 1'b0);
    wait_clk(4);
    check("R8 discarded", 16'(rx_avail), 16'd0);
    check("R8 still asleep", 16'(asleep), 16'd1);
    wait_clk(400);
    check("R8 woke", 16'(asleep), 16'd0);
    send_frame(9'h05A, 8, 1'b1, 1'b0);
    wait_clk(4);
    pop_check("R8 after wake", 9'h05A);

    // R9: address-mark wake
    wake_addr = 1;
    @(negedge clk); sleep_req = 1; @(negedge clk); sleep_req = 0;
    send_frame(9'h055, 9, 1'b1, 1'b0);
    wait_clk(400);
    check("R9 data ignored", 16'(rx_avail), 16'd0);
    check("R9 still asleep", 16'(asleep), 16'd1);
    send_frame(9'h1A5, 9, 1'b1, 1'b0);
    wait_clk(4);
    check("R9 woke", 16'(asleep), 16'd0);
    send_frame(9'h033, 9, 1'b1, 1'b0);
    wait_clk(4);
    pop_check("R9 address kept", 9'h1A5);
    pop_check("R9 data after", 9'h033);
    wake_addr = 0;

    // R10: single wire, echo heard
    single_wire = 1;
    wait_clk(4);
    check("R10 released idle", 16'(tx_oe), 16'd0);
    push(9'h04D);
    wait_clk(100);
    check("R10 driving", 16'(tx_oe), 16'd1);
    wait_clk(300);
    check("R10 released after", 16'(tx_oe), 16'd0);
    pop_check("R10 echo", 9'h04D);

    // R11: echo ignored, remote still heard
    echo_ignore = 1;
    push(9'h0B2);
    wait_clk(400);
    check("R11 own frame dropped", 16'(rx_avail), 16'd0);
    send_frame(9'h06E, 8, 1'b1, 1'b0);
    wait_clk(4);
    pop_check("R11 remote", 9'h06E);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule